// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the 32-bit register face of a serial port. A processor reaches it through a simple word-addressed read/write port. On the line side it takes received bytes from a deserialiser through a byte bus with a valid strobe, and it hands transmit bytes to a serialiser with a one-cycle strobe. Received bytes wait in a 16-entry FIFO. Software drains the FIFO through a combined status/data word. That word can be read at a non-destructive address or at a consuming address.

Interrupts come from a raw interrupt register. The FIFO level drives one of its bits, a transmit write sets two others, and software clears bits by writing ones to an acknowledge register. After a transmit write, the first acknowledge cannot clear bit 0. A mask selects which raw bits drive the single level interrupt line. Bus reads return data on the cycle after the request, together with a valid flag.

Top module: `sio_regfront`

## Requirements
- R1: After reset, the receive control word (byte offset 0x08) reads 0x0001_0000, so receive enable bit 3 is clear. Every other register reads 0, the status words read 0x0140_0000 and the interrupt line is low.
- R2: The words at 0x00, 0x04, 0x08, 0x1C and 0x2C read back the last value written to them. A read presents its data on `bus_rdata` with `bus_rvalid` high in the cycle after `bus_rd`.
- R3: The status words at 0x20 and 0x24 always have bits 24 and 22 set. Bit 16 is 1 when the FIFO holds data. Bits 7:0 hold the oldest byte, or 0 when the FIFO is empty. All other bits are 0.
- R4: A read of 0x20 removes the oldest byte when the FIFO is not empty. A read of 0x24 returns the same word and leaves the FIFO unchanged.
- R5: A byte on `rx_byte` with `rx_valid` is accepted only while bit 3 of the receive control word is 1. Otherwise the byte is discarded.
- R6: The FIFO holds 16 bytes and gives them back in arrival order. A byte that arrives while 16 are held is discarded.
- R7: Raw interrupt bit 3 (read at 0x34) is 1 exactly when the FIFO count of the previous cycle was non-zero.
- R8: A write to 0x1C pulses `tx_strobe` for one cycle in the next cycle, with `tx_byte` equal to the written bits 7:0. The same write sets raw interrupt bits 1 and 0 and sets a hidden pending flag.
- R9: A write to 0x30 clears every raw bit that is written as 1. If the pending flag is set, bit 0 is first removed from the written value and the flag is cleared. The word at 0x30 reads back the adjusted value.
- R10: The word at 0x38 reads as raw AND mask (mask at 0x2C). `irq` is high, in the same cycle as the raw register, exactly when that AND is non-zero.
- R11: Misaligned addresses and addresses at or above 0x3C read 0 and ignore writes. So do the reserved words inside the window (0x0C–0x18, 0x28). Writes to 0x20, 0x24, 0x34 and 0x38 have no effect.
- R12: When a byte is accepted in the same cycle as a consuming read of a non-empty FIFO, the count stays the same and byte order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the word access |
| bus_wr | input | 1 | Write request for one cycle |
| bus_rd | input | 1 | Read request for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | High in the cycle when `bus_rdata` answers a read |
| rx_byte | input | 8 | Received byte from the line side |
| rx_valid | input | 1 | Strobe marking `rx_byte` as new |
| tx_byte | output | 8 | Byte for the serialiser |
| tx_strobe | output | 1 | One-cycle pulse when `tx_byte` is new |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle, and that reset is held through the first clock edge. The stimulus issues every bus access through a task that raises exactly one request for a single cycle. The only overlap it creates is a received byte together with a consuming read, which R12 defines. Line-side bytes are driven both while the receiver is disabled and while the FIFO is full, so the discard paths are checked along with the accept paths.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [7:0] OFF_TXCTL  = 8'h00;
  localparam logic [7:0] OFF_TXDMA  = 8'h04;
  localparam logic [7:0] OFF_RXCTL  = 8'h08;
  localparam logic [7:0] OFF_DOUT   = 8'h1C;
  localparam logic [7:0] OFF_POP    = 8'h20;
  localparam logic [7:0] OFF_PEEK   = 8'h24;
  localparam logic [7:0] OFF_MASK   = 8'h2C;
  localparam logic [7:0] OFF_ACK    = 8'h30;
  localparam logic [7:0] OFF_RAW    = 8'h34;
  localparam logic [7:0] OFF_MASKED = 8'h38;
  localparam logic [7:0] WIN_END    = 8'h3C;

  localparam int STAT_AVAIL_BIT = 16;
  localparam int STAT_IDLE_BIT  = 22;
  localparam int STAT_READY_BIT = 24;
  localparam int RXEN_BIT       = 3;
  localparam int RAW_FIFO_BIT   = 3;

  localparam logic [31:0] RXCTL_RESET = 32'h0001_0000;
endpackage

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              nonempty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  // a full FIFO drops the byte even if a pop frees a slot in the same cycle
  assign do_push = push_req && (cnt_q < CNT_W'(DEPTH));
  assign do_pop  = pop_req && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head     = mem[rd_ptr];
  assign count    = cnt_q;
  assign nonempty = (cnt_q != '0);
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dout_we,
  input  logic              ack_we,
  input  logic              mask_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              fifo_busy,
  output logic [WORD_W-1:0] raw_q,
  output logic [WORD_W-1:0] mask_q,
  output logic [WORD_W-1:0] ack_q,
  output logic              irq
);
  logic              pend_q, pend_d;
  logic [WORD_W-1:0] raw_d, mask_d, ack_val;

  always_comb begin
    raw_d   = raw_q;
    pend_d  = pend_q;
    mask_d  = mask_we ? wdata : mask_q;
    ack_val = wdata;
    if (dout_we) begin
      raw_d[1:0] = 2'b11;
      pend_d     = 1'b1;
    end
    if (ack_we) begin
      if (pend_q) begin
        ack_val[0] = 1'b0;
        pend_d     = 1'b0;
      end
      raw_d = raw_d & ~ack_val;
    end
    raw_d[RAW_FIFO_BIT] = fifo_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
      ack_q  <= '0;
      pend_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
      pend_q <= pend_d;
      irq    <= |(raw_d & mask_d);
      if (ack_we) ack_q <= ack_val;
    end
  end
endmodule

// File: rtl/sio_regfront.sv
module sio_regfront
  import sio_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int FIFO_DEPTH = 16,
  localparam int WORD_W    = 32,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_valid,
  output logic [7:0]        tx_byte,
  output logic              tx_strobe,
  output logic              irq
);
  logic [WORD_W-1:0] txctl_q, txdma_q, rxctl_q, dout_q;
  logic [WORD_W-1:0] raw_q, mask_q, ack_q, stat_word, rd_mux;
  logic [7:0]        head;
  logic [CNT_W-1:0]  fill_cnt;
  logic              nonempty, legal;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  assign legal = (bus_addr[1:0] == 2'b00) && (bus_addr < ADDR_W'(WIN_END));

  sio_rx_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(8)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .push_req (rx_valid && rxctl_q[RXEN_BIT]),
    .push_data(rx_byte),
    .pop_req  (bus_rd && at(bus_addr, OFF_POP)),
    .head     (head),
    .count    (fill_cnt),
    .nonempty (nonempty)
  );

  sio_irq_ctrl #(.WORD_W(WORD_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .dout_we  (bus_wr && at(bus_addr, OFF_DOUT)),
    .ack_we   (bus_wr && at(bus_addr, OFF_ACK)),
    .mask_we  (bus_wr && at(bus_addr, OFF_MASK)),
    .wdata    (bus_wdata),
    .fifo_busy(nonempty),
    .raw_q    (raw_q),
    .mask_q   (mask_q),
    .ack_q    (ack_q),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      txctl_q   <= '0;
      txdma_q   <= '0;
      rxctl_q   <= RXCTL_RESET;
      dout_q    <= '0;
      tx_byte   <= '0;
      tx_strobe <= 1'b0;
    end else begin
      tx_strobe <= 1'b0;
      if (bus_wr) begin
        if (at(bus_addr, OFF_TXCTL)) txctl_q <= bus_wdata;
        if (at(bus_addr, OFF_TXDMA)) txdma_q <= bus_wdata;
        if (at(bus_addr, OFF_RXCTL)) rxctl_q <= bus_wdata;
        if (at(bus_addr, OFF_DOUT)) begin
          dout_q    <= bus_wdata;
          tx_byte   <= bus_wdata[7:0];
          tx_strobe <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    stat_word                 = '0;
    stat_word[STAT_READY_BIT] = 1'b1;
    stat_word[STAT_IDLE_BIT]  = 1'b1;
    stat_word[STAT_AVAIL_BIT] = nonempty;
    stat_word[7:0]            = nonempty ? head : 8'h00;
  end

  always_comb begin
    rd_mux = '0;
    if (legal) begin
      case (8'(bus_addr))
        OFF_TXCTL:           rd_mux = txctl_q;
        OFF_TXDMA:           rd_mux = txdma_q;
        OFF_RXCTL:           rd_mux = rxctl_q;
        OFF_DOUT:            rd_mux = dout_q;
        OFF_POP, OFF_PEEK:   rd_mux = stat_word;
        OFF_MASK:            rd_mux = mask_q;
        OFF_ACK:             rd_mux = ack_q;
        OFF_RAW:             rd_mux = raw_q;
        OFF_MASKED:          rd_mux = raw_q & mask_q;
        default:             rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/sio_regfront_chk.sv
module sio_regfront_chk #(
  parameter int ADDR_W     = 8,
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              rx_valid,
  input logic [7:0]        tx_byte,
  input logic              tx_strobe,
  input logic [CNT_W-1:0]  count,
  input logic [31:0]       raw,
  input logic              rxen
);
  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid); // R2

  AST_STATUS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == ADDR_W'(8'h20) || bus_addr == ADDR_W'(8'h24)))
      |=> (bus_rdata[24] && bus_rdata[22] && bus_rdata[16] == ($past(count) != 0))); // R3

  AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(8'h24) && !rx_valid) |=> $stable(count)); // R4

  AST_RX_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!rxen && !bus_wr) |=> (count <= $past(count))); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(FIFO_DEPTH)); // R6

  AST_RAW_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ##1 (raw[3] == ($past(count) != 0))); // R7

  AST_TX_PULSE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(8'h1C))
      |=> (tx_strobe && tx_byte == $past(bus_wdata[7:0]) && raw[1:0] == 2'b11)); // R8

  AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    tx_strobe |=> !tx_strobe); // R8

  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rxen && bus_rd && bus_addr == ADDR_W'(8'h20)
      && count != 0 && count < CNT_W'(FIFO_DEPTH)) |=> $stable(count)); // R12
endmodule

bind sio_regfront sio_regfront_chk #(.ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_rvalid(bus_rvalid),
  .rx_valid  (rx_valid),
  .tx_byte   (tx_byte),
  .tx_strobe (tx_strobe),
  .count     (fill_cnt),
  .raw       (raw_q),
  .rxen      (rxctl_q[3])
);

// File: tb/sim_sio_regfront.sv
module sim_sio_regfront;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0;
  logic [7:0]  tx_byte;
  logic        tx_strobe, irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  sio_regfront u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_byte(tx_byte),
    .tx_strobe(tx_strobe), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each returned read against the scoreboard
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) check("R2 unexpected read data", 32'h1, 32'h0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic rx(input logic [7:0] b);
    @(posedge clk); #1;
    rx_byte = b; rx_valid = 1'b1;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic rx_and_pop(input logic [7:0] b, input logic [31:0] exp);
    @(posedge clk); #1;
    rx_byte = b; rx_valid = 1'b1; bus_addr = 8'h20; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back("R12 pop during push");
    @(posedge clk); #1;
    rx_valid = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  localparam logic [31:0] ST_EMPTY = 32'h0140_0000;
  localparam logic [31:0] ST_AVAIL = 32'h0141_0000;

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(8'h00, 32'h0, "R1 txctl reset");
    rd(8'h08, 32'h0001_0000, "R1 rxctl reset");
    rd(8'h20, ST_EMPTY, "R1 status reset");
    rd(8'h34, 32'h0, "R1 raw reset");
    // R2 plain registers
    wr(8'h00, 32'hA5A5_0001);
    wr(8'h04, 32'h0000_0001);
    rd(8'h00, 32'hA5A5_0001, "R2 txctl readback");
    rd(8'h04, 32'h0000_0001, "R2 txdma readback");
    // R5 receiver disabled drops bytes
    rx(8'h99);
    idle(1);
    rd(8'h24, ST_EMPTY, "R5 byte dropped while disabled");
    // R3 R4 enable and fill
    wr(8'h08, 32'h0001_0008);
    rd(8'h08, 32'h0001_0008, "R2 rxctl readback");
    rx(8'h11); rx(8'h22); rx(8'h33);
    idle(2);
    rd(8'h24, ST_AVAIL | 32'h11, "R3 peek head");
    rd(8'h24, ST_AVAIL | 32'h11, "R4 peek leaves fifo");
    rd(8'h20, ST_AVAIL | 32'h11, "R4 pop returns head");
    rd(8'h24, ST_AVAIL | 32'h22, "R4 pop advanced head");
    // R7 R10 level interrupt
    rd(8'h34, 32'h8, "R7 raw bit3 while nonempty");
    wr(8'h2C, 32'h8);
    idle(1);
    @(negedge clk); check("R10 irq with mask 8", {31'b0, irq}, 32'h1);
    rd(8'h38, 32'h8, "R10 masked word");
    rd(8'h2C, 32'h8, "R2 mask readback");
    rd(8'h20, ST_AVAIL | 32'h22, "R4 pop second");
    rd(8'h20, ST_AVAIL | 32'h33, "R4 pop third");
    idle(2);
    rd(8'h34, 32'h0, "R7 raw bit3 cleared when empty");
    @(negedge clk); check("R10 irq low when empty", {31'b0, irq}, 32'h0);
    // R6 depth and overflow
    for (int i = 0; i < 17; i++) rx(8'h40 + 8'(i));
    for (int i = 0; i < 16; i++) rd(8'h20, ST_AVAIL | (32'h40 + i), "R6 fifo order");
    rd(8'h20, ST_EMPTY, "R6 seventeenth byte dropped");
    // R12 simultaneous push and pop
    rx(8'h77);
    rx_and_pop(8'h88, ST_AVAIL | 32'h77);
    rd(8'h24, ST_AVAIL | 32'h88, "R12 count kept");
    rd(8'h20, ST_AVAIL | 32'h88, "R12 order kept");
    rd(8'h24, ST_EMPTY, "R12 empty afterwards");
    idle(2);
    // R8 transmit
    wr(8'h1C, 32'h1234_56C3);
    @(negedge clk);
    check("R8 tx strobe", {31'b0, tx_strobe}, 32'h1);
    check("R8 tx byte", {24'b0, tx_byte}, 32'hC3);
    @(negedge clk);
    check("R8 strobe one cycle", {31'b0, tx_strobe}, 32'h0);
    rd(8'h1C, 32'h1234_56C3, "R2 dout readback");
    rd(8'h34, 32'h3, "R8 raw bits after write");
    // R9 acknowledge with pending protection
    wr(8'h30, 32'h3);
    rd(8'h34, 32'h1, "R9 bit0 protected");
    rd(8'h30, 32'h2, "R9 ack stores adjusted value");
    wr(8'h30, 32'h1);
    rd(8'h34, 32'h0, "R9 second ack clears bit0");
    rd(8'h30, 32'h1, "R9 ack readback");
    // R10 mask on transmit bit
    wr(8'h2C, 32'h1);
    wr(8'h1C, 32'h0000_0055);
    @(negedge clk); check("R10 irq raised by tx", {31'b0, irq}, 32'h1);
    rd(8'h38, 32'h1, "R10 masked tx bit");
    wr(8'h30, 32'h1);
    @(negedge clk); check("R9 protected ack keeps irq", {31'b0, irq}, 32'h1);
    wr(8'h30, 32'h1);
    @(negedge clk); check("R10 irq cleared", {31'b0, irq}, 32'h0);
    wr(8'h30, 32'h2);
    // R11 illegal and read-only addresses
    wr(8'h01, 32'hFFFF_FFFF);
    rd(8'h00, 32'hA5A5_0001, "R11 misaligned write ignored");
    rd(8'h01, 32'h0, "R11 misaligned read zero");
    wr(8'h40, 32'hDEAD_BEEF);
    rd(8'h40, 32'h0, "R11 outside window reads zero");
    wr(8'h0C, 32'h1234_5678);
    rd(8'h0C, 32'h0, "R11 reserved word");
    wr(8'h34, 32'hFFFF_FFFF);
    rd(8'h34, 32'h0, "R11 raw write ignored");
    wr(8'h24, 32'h0000_00AA);
    rd(8'h24, ST_EMPTY, "R11 status write ignored");
    @(negedge clk); check("R11 irq unaffected", {31'b0, irq}, 32'h0);
    idle(3);
    check("R2 all reads answered", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule